// File: doc/BRIEF.md
# Machine Cycle and Retired-Instruction Counters

This block keeps two 64-bit machine performance counters. One counts clock cycles and the other counts retired instructions. On every clock each counter adds a multi-bit step amount that the pipeline supplies. The step may be zero, one, or a large value. The carry from the low 32 bits into the high 32 bits is exact for any step size.

Software reaches the counters through a small register port. An access is marked by an enable, and a write strobe selects a write over a read. Reads are combinational from the current counter state. A write takes effect on the next rising clock edge. With a 32-bit register width, each counter is exposed as a low half and a high half. With a 64-bit register width, the low address alone carries the whole value.

A write to a counter takes priority over that counter's step in the same cycle, so the stored value is exactly the one written. On the retired-instruction counter, this means the instruction that performs the write is not counted. The other counter keeps stepping as normal. An access to an unknown address raises an illegal-access flag and changes nothing.

Top module: `mperf_counters`

## Requirements
- R1: After reset both counters are zero, and a read of any valid address returns zero.
- R2: With XLEN=32, address 0xB00 reads bits 31:0 of the cycle count and 0xB80 reads bits 63:32. Address 0xB02 reads bits 31:0 of the retired-instruction count and 0xB82 reads bits 63:32.
- R3: Without a write, each clock adds the zero-extended step input to the full 64-bit count. An overflow of the low half carries into the high half (low 0xFFFFFFFF plus 1 gives low 0, high 1).
- R4: With XLEN=32, a write to a low address loads bits 31:0 with the write data, keeps bits 63:32, and drops that counter's step for the cycle.
- R5: With XLEN=32, a write to a high address loads bits 63:32, keeps bits 31:0, and drops that counter's step for the cycle.
- R6: After a write cycle, stepping resumes from the written value. For example, low 110 and high 200 plus a step of 0xFFFFFFFF gives low 109 and high 201.
- R7: With XLEN=64, 0xB00 and 0xB02 read and write the full 64-bit value, and a write drops that cycle's step. The high addresses are illegal in this mode.
- R8: A write to one counter does not stop or change the stepping of the other counter in the same cycle.
- R9: An access (enable high) to any address that is not valid raises csr_illegal in the same cycle, reads zero, and modifies no counter. The counters keep stepping.
- R10: At most one counter half is selected by any address. Reads follow the current state, and writes land at the next rising edge while the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_inc | input | INC_W | Step added to the cycle counter each clock |
| ret_inc | input | INC_W | Step added to the retired-instruction counter each clock |
| csr_en | input | 1 | Register access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Access to an invalid address |

## Verification
The same stimulus drives a 32-bit instance and a 64-bit instance. Each is compared every clock against a behavioural model.

Directed steps of 1, 10 and 0xFFFFFFFF separate an exact 64-bit add from a truncated or late carry. A step held non-zero during writes to each half shows that the step is dropped only for the counter being written. It also shows the other counter still advances.

Invalid addresses, including the high halves in 64-bit mode, check that the flag is raised and that no counter is written. A long random mix of writes, reads, large steps and stray addresses covers the combinations that the directed steps do not reach.

// File: rtl/mperf_pkg.sv
package mperf_pkg;
    localparam int CNT_W   = 64;
    localparam int HALF_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int NUM_CNT = 2;

    // Counter k sits at base + 2*k; cycle is counter 0, instret counter 1.
    localparam logic [ADDR_W-1:0] LO_BASE = 12'hB00;
    localparam logic [ADDR_W-1:0] HI_BASE = 12'hB80;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_state_t;
endpackage

// File: rtl/mperf_csr_decode.sv
module mperf_csr_decode
    import mperf_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int N_CNT   = NUM_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              we,
    output logic [N_CNT-1:0]  lo_hit,
    output logic [N_CNT-1:0]  hi_hit,
    output logic [N_CNT-1:0]  lo_wr,
    output logic [N_CNT-1:0]  hi_wr,
    output logic              illegal
);
    localparam bit HI_OK = (XLEN == 32);

    for (genvar k = 0; k < N_CNT; k++) begin : g_sel
        assign lo_hit[k] = en && (addr == ADDR_W'(LO_BASE + 2 * k));
        if (HI_OK) begin : g_hi
            assign hi_hit[k] = en && (addr == ADDR_W'(HI_BASE + 2 * k));
        end else begin : g_nohi
            assign hi_hit[k] = 1'b0;
        end
    end

    assign lo_wr   = lo_hit & {N_CNT{we}};
    assign hi_wr   = hi_hit & {N_CNT{we}};
    assign illegal = en && !(|lo_hit) && !(|hi_hit);

    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lo_hit, hi_hit}));
    assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(|{lo_wr, hi_wr}));
    assert_wide_high_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!HI_OK && en && addr == HI_BASE) |-> illegal);
endmodule

// File: rtl/mperf_counter.sv
module mperf_counter
    import mperf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    cnt_state_t st_d, st_q;
    cnt_state_t lo_load, hi_load;

    if (DATA_W == CNT_W) begin : g_full
        assign lo_load = cnt_state_t'(wdata);
    end else begin : g_half
        assign lo_load = '{hi: st_q.hi, lo: wdata[HALF_W-1:0]};
    end
    assign hi_load = '{hi: wdata[HALF_W-1:0], lo: st_q.lo};

    always_comb begin
        st_d = st_q;
        if (wr_lo)      st_d = lo_load;
        else if (wr_hi) st_d = hi_load;
        else            st_d = cnt_state_t'(st_q + CNT_W'(inc));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q;

    assert_exact_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'($past(inc)));
    assert_low_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[HALF_W-1:0] == $past(wdata[HALF_W-1:0]));
    assert_high_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (count[CNT_W-1:HALF_W] == $past(wdata[HALF_W-1:0]))
               && (count[HALF_W-1:0] == $past(count[HALF_W-1:0])));
    if (DATA_W == CNT_W) begin : g_chk_full
        assert_full_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo |=> count == $past(CNT_W'(wdata)));
    end else begin : g_chk_half
        assert_low_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo |=> count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]));
    end
endmodule

// File: rtl/mperf_counters.sv
module mperf_counters
    import mperf_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int INC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  cyc_inc,
    input  logic [INC_W-1:0]  ret_inc,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal
);
    logic [NUM_CNT-1:0] lo_hit, hi_hit, lo_wr, hi_wr;
    logic [INC_W-1:0]   inc_vec [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    assign inc_vec[0] = cyc_inc;
    assign inc_vec[1] = ret_inc;

    mperf_csr_decode #(.XLEN(XLEN), .N_CNT(NUM_CNT)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (csr_addr),
        .en      (csr_en),
        .we      (csr_we),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .illegal (csr_illegal)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        mperf_counter #(.DATA_W(XLEN), .INC_W(INC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[k]),
            .wr_lo (lo_wr[k]),
            .wr_hi (hi_wr[k]),
            .wdata (csr_wdata),
            .count (cnt_val[k])
        );
    end

    always_comb begin
        csr_rdata = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (lo_hit[k]) csr_rdata = csr_rdata | cnt_val[k][XLEN-1:0];
            if (hi_hit[k]) csr_rdata = csr_rdata | XLEN'(cnt_val[k][CNT_W-1:HALF_W]);
        end
    end

    assert_instret_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_wr[0] || hi_wr[0]) && !(lo_wr[1] || hi_wr[1]))
        |=> cnt_val[1] == $past(cnt_val[1]) + CNT_W'($past(ret_inc)));
    assert_cycle_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_wr[1] || hi_wr[1]) && !(lo_wr[0] || hi_wr[0]))
        |=> cnt_val[0] == $past(cnt_val[0]) + CNT_W'($past(cyc_inc)));
    assert_illegal_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);
endmodule

// File: tb/mperf_counters_test.sv
`timescale 1ns/1ps
module mperf_counters_test;
    localparam logic [11:0] A_CL = 12'hB00;
    localparam logic [11:0] A_RL = 12'hB02;
    localparam logic [11:0] A_CH = 12'hB80;
    localparam logic [11:0] A_RH = 12'hB82;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cyc_inc = '0, ret_inc = '0;
    logic        csr_en = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] wd = '0;
    logic [31:0] rd32;
    logic [63:0] rd64;
    logic        ill32, ill64;

    int compared = 0;
    int mismatched = 0;

    logic [63:0] mc32 = '0, mr32 = '0, mc64 = '0, mr64 = '0;

    always #4 clk = ~clk;

    mperf_counters #(.XLEN(32), .INC_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_inc(cyc_inc), .ret_inc(ret_inc),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(wd[31:0]), .csr_rdata(rd32), .csr_illegal(ill32));

    mperf_counters #(.XLEN(64), .INC_W(32)) uut_w64 (
        .clk(clk), .rst_n(rst_n), .cyc_inc(cyc_inc), .ret_inc(ret_inc),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(wd), .csr_rdata(rd64), .csr_illegal(ill64));

    function automatic bit legal(input logic [11:0] a, input int xl);
        return (a == A_CL) || (a == A_RL) || (xl == 32 && (a == A_CH || a == A_RH));
    endfunction

    function automatic logic [63:0] mread(input logic [63:0] c, input logic [63:0] r,
                                          input logic [11:0] a, input int xl);
        if (!legal(a, xl)) return 64'd0;
        if (a == A_CL) return (xl == 32) ? {32'd0, c[31:0]} : c;
        if (a == A_RL) return (xl == 32) ? {32'd0, r[31:0]} : r;
        if (a == A_CH) return {32'd0, c[63:32]};
        return {32'd0, r[63:32]};
    endfunction

    function automatic logic [63:0] nextv(input logic [63:0] cur, input bit wlo, input bit whi,
                                          input logic [63:0] d, input logic [31:0] inc, input int xl);
        logic [63:0] v;
        v = cur;
        if (wlo) begin
            if (xl == 64) v = d;
            else v[31:0] = d[31:0];
        end else if (whi) v[63:32] = d[31:0];
        else v = cur + {32'd0, inc};
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, compare outputs with the model, clock, advance the model.
    task automatic step(input logic [11:0] a, input bit e, input bit w, input logic [63:0] d,
                        input logic [31:0] ci, input logic [31:0] ri, input string tag);
        bit ok32, ok64;
        csr_addr = a; csr_en = e; csr_we = w; wd = d; cyc_inc = ci; ret_inc = ri;
        #1;
        ok32 = e && legal(a, 32);
        ok64 = e && legal(a, 64);
        chk({tag, " rd32"}, {32'd0, rd32}, e ? mread(mc32, mr32, a, 32) : 64'd0);
        chk({tag, " ill32"}, {63'd0, ill32}, {63'd0, e && !legal(a, 32)});
        chk({tag, " rd64"}, rd64, e ? mread(mc64, mr64, a, 64) : 64'd0);
        chk({tag, " ill64"}, {63'd0, ill64}, {63'd0, e && !legal(a, 64)});
        @(posedge clk);
        mc32 = nextv(mc32, ok32 && w && a == A_CL, ok32 && w && a == A_CH, d, ci, 32);
        mr32 = nextv(mr32, ok32 && w && a == A_RL, ok32 && w && a == A_RH, d, ri, 32);
        mc64 = nextv(mc64, ok64 && w && a == A_CL, 1'b0, d, ci, 64);
        mr64 = nextv(mr64, ok64 && w && a == A_RL, 1'b0, d, ri, 64);
        @(negedge clk);
    endtask

    task automatic exp32(input logic [11:0] a, input logic [31:0] e, input string tag);
        csr_addr = a; csr_en = 1'b1; csr_we = 1'b0; cyc_inc = '0; ret_inc = '0;
        #1;
        chk(tag, {32'd0, rd32}, {32'd0, e});
    endtask

    task automatic exp64(input logic [11:0] a, input logic [63:0] e, input bit ei, input string tag);
        csr_addr = a; csr_en = 1'b1; csr_we = 1'b0; cyc_inc = '0; ret_inc = '0;
        #1;
        chk({tag, " data"}, rd64, e);
        chk({tag, " flag"}, {63'd0, ill64}, {63'd0, ei});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp32(A_CL, 32'd0, "R1 reset cycle low");
        rst_n = 1'b1;
        @(negedge clk);
        exp32(A_CL, 32'd0, "R1 cycle low");
        exp32(A_CH, 32'd0, "R1 cycle high");
        exp32(A_RL, 32'd0, "R1 instret low");
        exp32(A_RH, 32'd0, "R1 instret high");
        exp64(A_CL, 64'd0, 1'b0, "R1 wide cycle");

        step(A_CL, 1, 0, 64'd0, 32'd1, 32'd0, "R3 step1");
        exp32(A_CL, 32'd1, "R3 single step low");
        exp32(A_CH, 32'd0, "R2 high still zero");
        step(A_CL, 1, 1, 64'hFFFF_FFFF, 32'd9, 32'd0, "R4 load low");
        exp32(A_CL, 32'hFFFF_FFFF, "R4 low written, step dropped");
        exp32(A_CH, 32'd0, "R4 high kept");
        step(A_CL, 1, 0, 64'd0, 32'd1, 32'd0, "R3 carry");
        exp32(A_CL, 32'd0, "R3 carry low");
        exp32(A_CH, 32'd1, "R3 carry high");
        step(A_CH, 1, 1, 64'd200, 32'd5, 32'd0, "R5 load high");
        exp32(A_CH, 32'd200, "R5 high written");
        exp32(A_CL, 32'd0, "R5 low not advanced");
        step(A_CL, 1, 1, 64'd110, 32'd3, 32'd0, "R4 load low 110");
        exp32(A_CL, 32'd110, "R4 low 110");
        step(A_CL, 1, 0, 64'd0, 32'd10, 32'd0, "R3 step10");
        exp32(A_CL, 32'd120, "R3 step of 10");
        step(A_CL, 1, 1, 64'd110, 32'd0, 32'd0, "R4 reload 110");
        step(A_CL, 1, 0, 64'd0, 32'hFFFF_FFFF, 32'd0, "R6 big step");
        exp32(A_CL, 32'd109, "R6 low after big step");
        exp32(A_CH, 32'd201, "R6 high after big step");

        step(A_RL, 1, 1, 64'd1000, 32'd4, 32'd7, "R8 write instret");
        exp32(A_RL, 32'd1000, "R8 instret write not counted");
        exp32(A_CL, 32'd113, "R8 cycle kept stepping");
        step(A_CL, 1, 1, 64'd50, 32'd2, 32'd1, "R8 write cycle");
        exp32(A_CL, 32'd50, "R8 cycle written");
        exp32(A_RL, 32'd1001, "R8 instret kept stepping");
        step(A_RL, 1, 0, 64'd0, 32'd0, 32'd1, "R6 instret resumes");
        exp32(A_RL, 32'd1002, "R6 instret resumes");
        step(A_RH, 1, 1, 64'd5, 32'd0, 32'd9, "R5 instret high");
        exp32(A_RH, 32'd5, "R5 instret high written");
        exp32(A_RL, 32'd1002, "R5 instret low held");

        step(12'hB01, 1, 1, 64'hDEAD, 32'd0, 32'd0, "R9 stray write");
        exp32(A_CL, 32'd50, "R9 cycle untouched");
        exp32(A_RL, 32'd1002, "R9 instret untouched");
        exp32(A_RH, 32'd5, "R9 instret high untouched");
        step(A_CL, 0, 1, 64'd77, 32'd0, 32'd0, "R10 no enable no write");
        exp32(A_CL, 32'd50, "R10 disabled write ignored");

        step(A_CL, 1, 1, 64'h0000_0012_3456_789A, 32'd8, 32'd0, "R7 full load");
        exp64(A_CL, 64'h0000_0012_3456_789A, 1'b0, "R7 wide full value");
        step(A_CH, 1, 1, 64'd77, 32'd0, 32'd0, "R7 high write in wide mode");
        exp64(A_CH, 64'd0, 1'b1, "R7 wide high illegal");
        exp64(A_CL, 64'h0000_0012_3456_789A, 1'b0, "R7 wide unchanged");

        for (int i = 0; i < 400; i++) begin
            int unsigned pick;
            logic [11:0] a;
            pick = $urandom_range(0, 4);
            a = (pick == 0) ? A_CL : (pick == 1) ? A_RL : (pick == 2) ? A_CH :
                (pick == 3) ? A_RH : 12'($urandom);
            step(a, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 {$urandom, $urandom},
                 ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 5)),
                 ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 5)),
                 "R3 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule